// File: doc/BRIEF.md
# Time-Multiplexed Perceptron Classifier

This block runs inference for a small fixed feed-forward network: six signed sensor readings go in, and a 4-bit class number comes out. There are two hidden layers of eight neurons each and a single output neuron. They are all evaluated one after another on a single neuron datapath. That datapath holds eight parallel multipliers, an adder that takes the eight products and the bias, and an activation stage that can be set to rectify or to pass the sum through.

A host places a vector on the input port and pulses `start`. The block takes a copy of the vector on that edge. It then works through the first hidden layer, the second hidden layer and finally the output neuron. When done, it writes the class register and pulses `done` for one cycle. The coefficients sit in a constant store that is filled at build time from the `SEED` parameter.

A build option chooses the datapath variant. With the register after the multipliers, each neuron takes two cycles and the path through the adder is shorter. Without it, each neuron takes one cycle.

Top module: `mlp_engine`

## Requirements
- R1: Each neuron computes sum = bias + Σ x_i·w_i as an exact signed integer. The first hidden layer (layer l=0) reads the six inputs, which are 17-bit two's-complement values. Input i is at bits [17·i+16 : 17·i] of `in_vec`. The second hidden layer (l=1) reads the eight first-layer values. The output neuron (l=2, n=0) reads the eight second-layer values.
- R2: The weight of neuron n in layer l for operand i is w = (((7n + 5i + 11l + SEED) mod 17) − 8)·12. The bias is b = (((3n + 5l + SEED) mod 9) − 4)·64. Both are in units of 1/256.
- R3: A hidden neuron stores floor(sum/256) when that value is positive, capped at 65535. A negative sum stores 0.
- R4: The output neuron uses identity activation. The class is floor(sum/256), saturated to the range 0..15.
- R5: Without the post-multiplier register, `done` rises 20 clock edges after the edge that accepts `start`. The neuron order is layer 0, then layer 1, then the output neuron.
- R6: With the post-multiplier register, `done` rises 37 edges after the accepting edge, and the class matches the one the other variant produces.
- R7: A `start` pulse that arrives while an inference is running is ignored. It neither restarts the run nor queues a second one.
- R8: `done` is high for exactly one cycle per accepted start, at the same time as `result` updates. `result` holds its value between `done` pulses.
- R9: After reset, `result` is 0 and `done` is 0.
- R10: `in_vec` is sampled only on the edge that accepts `start`. Changes to it during a run do not affect that run's class.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts an inference when idle |
| in_vec | input | 102 | Six packed signed 17-bit inputs |
| result | output | 4 | Registered class number |
| done | output | 1 | One-cycle pulse when result updates |

## Verification
The checker watches several properties on every cycle. It confirms that `done` lasts exactly one cycle, and that it comes at exactly the fixed latency after an accepted start and at no other time. It also confirms that `result` holds between pulses and that no stored hidden value is ever negative. The correctness of the class itself, of saturation at both ends, of ignoring the input vector after capture, and of the two variants agreeing can only be shown by the bench. It does this by sweeping input magnitudes from a few units up to full scale and comparing each class against values computed arithmetically in the bench.

// File: rtl/mlp_pkg.sv
package mlp_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LOAD,
    SQ_FETCH,
    SQ_RUN,
    SQ_FIN
  } seq_state_t;

  function automatic int coef_weight(input int l, input int n, input int i, input int seed);
    return (((7 * n + 5 * i + 11 * l + seed) % 17) - 8) * 12;
  endfunction

  function automatic int coef_bias(input int l, input int n, input int seed);
    return (((3 * n + 5 * l + seed) % 9) - 4) * 64;
  endfunction

endpackage

// File: rtl/mlp_coef_rom.sv
module mlp_coef_rom #(
  parameter int N_IN   = 6,
  parameter int N_HID  = 8,
  parameter int LANES  = 8,
  parameter int W_W    = 16,
  parameter int N_NEUR = 17,
  parameter int IDX_W  = 5,
  parameter int SEED   = 0,
  localparam int ROW_W = (LANES + 1) * W_W
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] addr,
  output logic [ROW_W-1:0] row_q
);
  import mlp_pkg::*;

  logic [ROW_W-1:0] mem [N_NEUR];

  initial begin
    for (int k = 0; k < N_NEUR; k++) begin
      int l;
      int n;
      logic [ROW_W-1:0] r;
      l = (k < N_HID) ? 0 : ((k < 2 * N_HID) ? 1 : 2);
      n = (l == 2) ? 0 : (k % N_HID);
      r = '0;
      for (int i = 0; i < LANES; i++) begin
        if (!(l == 0 && i >= N_IN)) begin
          r[i*W_W +: W_W] = W_W'(coef_weight(l, n, i, SEED));
        end
      end
      r[LANES*W_W +: W_W] = W_W'(coef_bias(l, n, SEED));
      mem[k] = r;
    end
  end

  always_ff @(posedge clk) begin
    row_q <= mem[addr];
  end
endmodule

// File: rtl/mlp_sequencer.sv
module mlp_sequencer #(
  parameter int N_NEUR = 17,
  parameter int IDX_W  = 5,
  parameter bit PIPE   = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             load_en,
  output logic             wr_en,
  output logic             fin,
  output logic             busy,
  output logic [IDX_W-1:0] nidx,
  output logic [IDX_W-1:0] rom_addr
);
  import mlp_pkg::*;

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_NEUR - 1);

  seq_state_t state;
  logic       ph;
  logic       adv;

  assign adv      = (state == SQ_RUN) && (PIPE ? ph : 1'b1);
  assign wr_en    = adv;
  assign load_en  = (state == SQ_IDLE) && start;
  assign fin      = (state == SQ_FIN);
  assign busy     = (state != SQ_IDLE);
  assign rom_addr = (adv && nidx != LAST) ? IDX_W'(nidx + 1'b1) : nidx;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SQ_IDLE;
      nidx  <= '0;
      ph    <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: begin
          nidx <= '0;
          ph   <= 1'b0;
          if (start) state <= SQ_LOAD;
        end
        SQ_LOAD:  state <= SQ_FETCH;
        SQ_FETCH: state <= SQ_RUN;
        SQ_RUN: begin
          ph <= ~ph;
          if (adv) begin
            if (nidx == LAST) state <= SQ_FIN;
            else              nidx  <= IDX_W'(nidx + 1'b1);
          end
        end
        SQ_FIN: begin
          state <= SQ_IDLE;
          nidx  <= '0;
          ph    <= 1'b0;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mlp_neuron.sv
module mlp_neuron #(
  parameter int LANES = 8,
  parameter int OP_W  = 17,
  parameter int W_W   = 16,
  parameter int ACC_W = 40,
  parameter bit PIPE  = 1'b0,
  localparam int PROD_W = OP_W + W_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [OP_W-1:0]  opnd [LANES],
  input  logic signed [W_W-1:0]   wts  [LANES],
  input  logic signed [W_W-1:0]   bias,
  input  logic                    relu,
  output logic signed [ACC_W-1:0] act_o
);
  logic signed [PROD_W-1:0] prod_c [LANES];
  logic signed [PROD_W-1:0] prod_u [LANES];
  logic signed [ACC_W-1:0]  sum;

  for (genvar g = 0; g < LANES; g++) begin : g_mul
    assign prod_c[g] = PROD_W'(opnd[g]) * PROD_W'(wts[g]);
  end

  if (PIPE) begin : g_preg
    always_ff @(posedge clk) begin
      for (int i = 0; i < LANES; i++) begin
        if (rst) prod_u[i] <= '0;
        else     prod_u[i] <= prod_c[i];
      end
    end
  end else begin : g_comb
    logic unused_clk_rst;
    assign unused_clk_rst = clk ^ rst;
    for (genvar g = 0; g < LANES; g++) begin : g_pass
      assign prod_u[g] = prod_c[g];
    end
  end

  always_comb begin
    sum = ACC_W'(bias);
    for (int i = 0; i < LANES; i++) begin
      sum = sum + ACC_W'(prod_u[i]);
    end
    act_o = (relu && sum < 0) ? '0 : sum;
  end
endmodule

// File: rtl/mlp_engine.sv
module mlp_engine #(
  parameter int IN_W         = 17,
  parameter int W_W          = 16,
  parameter int ACC_W        = 40,
  parameter int FRAC         = 8,
  parameter int N_IN         = 6,
  parameter int N_HID        = 8,
  parameter int RES_W        = 4,
  parameter bit POST_MUL_REG = 1'b0,
  parameter int SEED         = 0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [N_IN*IN_W-1:0]   in_vec,
  output logic [RES_W-1:0]       result,
  output logic                   done
);
  localparam int LANES   = (N_IN > N_HID) ? N_IN : N_HID;
  localparam int N_NEUR  = 2 * N_HID + 1;
  localparam int IDX_W   = $clog2(N_NEUR);
  localparam int HS_W    = (N_HID > 1) ? $clog2(N_HID) : 1;
  localparam int ACT_W   = IN_W;
  localparam int H_MAX   = 2 ** (ACT_W - 1) - 1;
  localparam int RES_MAX = 2 ** RES_W - 1;
  localparam int LAT     = N_NEUR * (POST_MUL_REG ? 2 : 1) + 3;
  localparam int ROW_W   = (LANES + 1) * W_W;

  logic             load_en, wr_en, fin, busy;
  logic [IDX_W-1:0] nidx, rom_addr;
  logic [ROW_W-1:0] rom_row;

  logic signed [IN_W-1:0]  xbuf [N_IN];
  logic signed [ACT_W-1:0] h1   [N_HID];
  logic signed [ACT_W-1:0] h2   [N_HID];
  logic signed [ACT_W-1:0] opnd [LANES];
  logic signed [W_W-1:0]   wts  [LANES];
  logic signed [W_W-1:0]   bias;
  logic signed [ACC_W-1:0] act_o, hval, out_q, ov;
  logic signed [ACT_W-1:0] hq;
  logic                    relu;
  logic [IDX_W-1:0]        h2_idx;

  mlp_sequencer #(.N_NEUR(N_NEUR), .IDX_W(IDX_W), .PIPE(POST_MUL_REG)) u_seq (
    .clk(clk), .rst(rst), .start(start), .load_en(load_en), .wr_en(wr_en),
    .fin(fin), .busy(busy), .nidx(nidx), .rom_addr(rom_addr)
  );

  mlp_coef_rom #(
    .N_IN(N_IN), .N_HID(N_HID), .LANES(LANES), .W_W(W_W),
    .N_NEUR(N_NEUR), .IDX_W(IDX_W), .SEED(SEED)
  ) u_rom (
    .clk(clk), .addr(rom_addr), .row_q(rom_row)
  );

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      opnd[i] = '0;
      wts[i]  = rom_row[i*W_W +: W_W];
      if (nidx < IDX_W'(N_HID)) begin
        if (i < N_IN) opnd[i] = ACT_W'(xbuf[i]);
      end else if (nidx < IDX_W'(2 * N_HID)) begin
        if (i < N_HID) opnd[i] = h1[i];
      end else begin
        if (i < N_HID) opnd[i] = h2[i];
      end
    end
    bias = rom_row[LANES*W_W +: W_W];
    relu = (nidx != IDX_W'(N_NEUR - 1));
  end

  mlp_neuron #(
    .LANES(LANES), .OP_W(ACT_W), .W_W(W_W), .ACC_W(ACC_W), .PIPE(POST_MUL_REG)
  ) u_neuron (
    .clk(clk), .rst(rst), .opnd(opnd), .wts(wts), .bias(bias),
    .relu(relu), .act_o(act_o)
  );

  assign hval   = act_o >>> FRAC;
  assign hq     = (hval > ACC_W'(H_MAX)) ? ACT_W'(H_MAX) : hval[ACT_W-1:0];
  assign h2_idx = IDX_W'(nidx - IDX_W'(N_HID));
  assign ov     = out_q >>> FRAC;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_IN; i++)  xbuf[i] <= '0;
      for (int i = 0; i < N_HID; i++) begin
        h1[i] <= '0;
        h2[i] <= '0;
      end
      out_q <= '0;
    end else begin
      if (load_en) begin
        for (int i = 0; i < N_IN; i++) xbuf[i] <= in_vec[i*IN_W +: IN_W];
      end
      if (wr_en) begin
        if (nidx < IDX_W'(N_HID))          h1[nidx[HS_W-1:0]]   <= hq;
        else if (nidx < IDX_W'(2 * N_HID)) h2[h2_idx[HS_W-1:0]] <= hq;
        else                               out_q                <= act_o;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= fin;
      if (fin) begin
        if (ov < 0)                       result <= '0;
        else if (ov > ACC_W'(RES_MAX))    result <= RES_W'(RES_MAX);
        else                              result <= ov[RES_W-1:0];
      end
    end
  end
endmodule

// File: rtl/mlp_engine_chk.sv
module mlp_engine_chk #(
  parameter int N_HID = 8,
  parameter int ACT_W = 17,
  parameter int RES_W = 4,
  parameter int LAT   = 20
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    start,
  input logic                    busy,
  input logic                    done,
  input logic [RES_W-1:0]        result,
  input logic signed [ACT_W-1:0] h1 [N_HID],
  input logic signed [ACT_W-1:0] h2 [N_HID]
);
  localparam int CW = $clog2(LAT + 2) + 1;

  logic          run_q;
  logic [CW-1:0] cnt;
  logic [2*N_HID-1:0] signs;

  always_comb begin
    for (int i = 0; i < N_HID; i++) begin
      signs[i]         = h1[i][ACT_W-1];
      signs[N_HID + i] = h2[i][ACT_W-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt   <= '0;
    end else if (start && !busy) begin
      run_q <= 1'b1;
      cnt   <= '0;
    end else if (run_q) begin
      cnt <= CW'(cnt + 1'b1);
      if (done) run_q <= 1'b0;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result)); // R8
  AST_DONE_AT_LAT: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_q && cnt == CW'(LAT))); // R5
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
    (run_q && cnt == CW'(LAT)) |-> done); // R7
  AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R8
  AST_RELU_NONNEG: assert property (@(posedge clk) disable iff (rst)
    $countones(signs) == 0); // R3
endmodule

bind mlp_engine mlp_engine_chk #(
  .N_HID(N_HID), .ACT_W(ACT_W), .RES_W(RES_W), .LAT(LAT)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .result(result), .h1(h1), .h2(h2)
);

// File: tb/mlp_engine_tb.sv
module mlp_engine_tb_top;
  localparam int IN_W = 17;
  localparam int N_IN = 6;
  localparam int SEED = 0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [N_IN*IN_W-1:0] in_vec = '0;
  logic [3:0] res_a, res_b;
  logic done_a, done_b;

  int total = 0;
  int bad = 0;
  int unsigned lcg = 32'h1234_5678;

  always #5 clk = ~clk;

  mlp_engine #(.POST_MUL_REG(1'b0), .SEED(SEED)) dut_i (
    .clk(clk), .rst(rst), .start(start), .in_vec(in_vec),
    .result(res_a), .done(done_a)
  );

  mlp_engine #(.POST_MUL_REG(1'b1), .SEED(SEED)) dut_scp_i (
    .clk(clk), .rst(rst), .start(start), .in_vec(in_vec),
    .result(res_b), .done(done_b)
  );

  function automatic longint wt(int l, int n, int i);
    return longint'((((7 * n + 5 * i + 11 * l + SEED) % 17) - 8) * 12);
  endfunction

  function automatic longint bs(int l, int n);
    return longint'((((3 * n + 5 * l + SEED) % 9) - 4) * 64);
  endfunction

  function automatic longint hid(longint s);
    longint q;
    if (s < 0) return 0;
    q = s >>> 8;
    return (q > 65535) ? 65535 : q;
  endfunction

  function automatic int model(logic [N_IN*IN_W-1:0] v);
    longint x [6];
    longint a [8];
    longint b [8];
    longint s, o;
    for (int i = 0; i < 6; i++) x[i] = longint'($signed(v[i*IN_W +: IN_W]));
    for (int n = 0; n < 8; n++) begin
      s = bs(0, n);
      for (int i = 0; i < 6; i++) s += x[i] * wt(0, n, i);
      a[n] = hid(s);
    end
    for (int n = 0; n < 8; n++) begin
      s = bs(1, n);
      for (int i = 0; i < 8; i++) s += a[i] * wt(1, n, i);
      b[n] = hid(s);
    end
    s = bs(2, 0);
    for (int i = 0; i < 8; i++) s += b[i] * wt(2, 0, i);
    o = s >>> 8;
    if (o < 0) return 0;
    if (o > 15) return 15;
    return int'(o);
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(logic [N_IN*IN_W-1:0] v, bit scramble, bit poke);
    int lat_a = 0, lat_b = 0, cnt_a = 0, cnt_b = 0, ra = 0, rb = 0, exp;
    exp = model(v);
    @(negedge clk);
    in_vec = v;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (scramble) in_vec = ~v;
    for (int k = 1; k <= 60; k++) begin
      if (poke && k == 5) begin
        in_vec = ~v;
        start  = 1'b1;
      end
      @(negedge clk);
      if (poke && k == 5) start = 1'b0;
      if (done_a) begin
        cnt_a++;
        if (lat_a == 0) begin lat_a = k; ra = int'(res_a); end
      end
      if (done_b) begin
        cnt_b++;
        if (lat_b == 0) begin lat_b = k; rb = int'(res_b); end
      end
      if (k == lat_a + 3 && lat_a != 0) check("R8 hold", int'(res_a), ra);
    end
    check("R5 latency", lat_a, 20);
    check("R6 latency", lat_b, 37);
    check(poke ? "R7 class" : (scramble ? "R10 class" : "R1 R2 R3 R4 class"), ra, exp);
    check("R6 class", rb, exp);
    check(poke ? "R7 single done" : "R8 single done", cnt_a, 1);
    check("R8 single done scp", cnt_b, 1);
  endtask

  function automatic logic [N_IN*IN_W-1:0] gen_vec(int s);
    logic [N_IN*IN_W-1:0] v;
    longint m, x;
    m = longint'(1) << s;
    for (int i = 0; i < N_IN; i++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      x = longint'(lcg >> 8) % (2 * m) - m;
      if (x > 65535) x = 65535;
      if (x < -65536) x = -65536;
      v[i*IN_W +: IN_W] = IN_W'(x);
    end
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N_IN*IN_W-1:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R9 result", int'(res_a), 0);
    check("R9 done", int'(done_a), 0);
    check("R9 result scp", int'(res_b), 0);
    check("R9 done scp", int'(done_b), 0);

    run_vec('0, 1'b0, 1'b0);
    for (int i = 0; i < N_IN; i++) v[i*IN_W +: IN_W] = 17'h0FFFF;
    run_vec(v, 1'b0, 1'b0);
    for (int i = 0; i < N_IN; i++) v[i*IN_W +: IN_W] = 17'h10000;
    run_vec(v, 1'b0, 1'b0);
    for (int i = 0; i < N_IN; i++) v[i*IN_W +: IN_W] = (i % 2) ? 17'h10000 : 17'h0FFFF;
    run_vec(v, 1'b0, 1'b0);

    for (int r = 0; r < 3; r++) begin
      for (int s = 0; s <= 16; s++) run_vec(gen_vec(s), 1'b0, 1'b0);
    end
    for (int s = 2; s <= 14; s += 3) run_vec(gen_vec(s), 1'b1, 1'b0);
    for (int s = 3; s <= 15; s += 4) run_vec(gen_vec(s), 1'b0, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule